// File: doc/BRIEF.md
# Resampled Waveform Capture Buffer

This block records sets of resampled waveform samples into a 2048-word, 32-bit capture memory. Each set carries one 32-bit word for each of four channels and arrives in one cycle on a valid-qualified bus. Once armed, the block stores sets one after another from the first buffer location. A sticky ready flag then tells the host that a page, or the whole buffer, holds fresh data. The flag can drive an interrupt line through a mask bit. The host reads the stored words through a registered read port at host addresses 0x800 to 0xFFF.

Two fill modes exist. In the 128-point mode, 512 sets fill the buffer once, which is four line cycles of 128 sets each. The flag rises when the last set lands, and capture stops there. In the 1024-point mode, the buffer is split into sixteen pages of 128 words and is rewritten in a ring. The flag rises each time a page closes, and a page number output names that page. The host starts a new capture by dropping the capture enable and raising it again. That restarts filling at the first location.

Top module: `wavecap_ctrl`

## Requirements
- R1: After reset, ready_o, irq_o and rd_valid_o are 0 and page_o is 0.
- R2: The n-th accepted set after arming is stored so that channel c (bits [32c+31:32c] of smp_data_i) is read back at host address 0x800 + 4n + c.
- R3: A set is stored only when cap_en_i is 1 and src_sel_i is 0. Sets offered at other times are dropped, the memory keeps its contents, and the fill position is held.
- R4: With mode_i = 0 (128-point mode), the 512th stored set raises ready_o. Sets offered after that are dropped until the capture is re-armed.
- R5: With mode_i = 1 (1024-point mode), every 32nd stored set (128 words) raises ready_o. page_o then holds the index 0..15 of the page just filled, which is (word offset from 0x800) / 128. After page 15, filling wraps to 0x800.
- R6: ready_o stays 1 until a cycle with status_clr_i = 1 and no fill event. A fill event in the same cycle as the clear leaves ready_o at 1.
- R7: irq_o is 1 exactly when ready_o and irq_mask_i are both 1.
- R8: A 0-to-1 change of cap_en_i re-arms the block. It clears the full state, and the set offered in that same cycle is stored at 0x800.
- R9: A read requested with rd_en_i returns its data with rd_valid_o = 1 one cycle later. rd_valid_o is 0 in the cycle after a cycle without rd_en_i. A read of the address being written in the same cycle returns the previous content.
- R10: A read of an address below 0x800 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en_i | input | 1 | Capture enable; a rising change re-arms |
| src_sel_i | input | 1 | Source select; 0 selects resampled data for capture |
| mode_i | input | 1 | 0: 128-point one-shot fill, 1: 1024-point paged ring fill |
| irq_mask_i | input | 1 | Interrupt mask for the ready flag |
| status_clr_i | input | 1 | Write-one-to-clear pulse for the ready flag |
| smp_valid_i | input | 1 | Sample set valid |
| smp_data_i | input | 128 | Four 32-bit channel words, channel 0 in the low bits |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | 12 | Host word address |
| rd_data_o | output | 32 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| ready_o | output | 1 | Sticky ready flag |
| page_o | output | 4 | Index of the most recently filled page |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions check the following on every cycle:
- the flag holds and clears as R6 requires, and any page or buffer event raises it on the next cycle;
- irq_o follows the mask;
- no write happens while capture is disabled or another source is selected;
- nothing is written in the cycle after the buffer fills;
- read valid lags the request by exactly one cycle.

Only the bench scenarios can show where each word lands in memory, the count of sets before the flag rises, the page numbers and the wrap, the restart at 0x800 on re-arm, and that dropped sets leave the memory unchanged. The bench shows the last point by reading the memory back through the host port.

// File: rtl/wavecap_pkg.sv
`timescale 1ns/1ps
package wavecap_pkg;

  typedef enum logic {
    MODE_128  = 1'b0,
    MODE_1024 = 1'b1
  } fill_mode_e;

  // True when the set at index set_idx is the final set of its page.
  function automatic logic set_closes_page(input int unsigned set_idx,
                                           input int unsigned sets_per_page);
    return ((set_idx + 1) % sets_per_page) == 0;
  endfunction

  // True when a host address lies inside the capture window.
  function automatic logic addr_in_window(input int unsigned addr,
                                          input int unsigned base,
                                          input int unsigned depth);
    return (addr >= base) && (addr < base + depth);
  endfunction

endpackage

// File: rtl/wavecap_bank.sv
`timescale 1ns/1ps
module wavecap_bank #(
  parameter  int unsigned DEPTH = 512,
  parameter  int unsigned W     = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  // Read sees the content from before a same-cycle write.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/wavecap_fill.sv
`timescale 1ns/1ps
module wavecap_fill
  import wavecap_pkg::*;
#(
  parameter  int unsigned SETS          = 512,
  parameter  int unsigned SETS_PER_PAGE = 32,
  localparam int unsigned PW            = $clog2(SETS),
  localparam int unsigned PGW           = $clog2(SETS / SETS_PER_PAGE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en_i,
  input  logic           src_sel_i,
  input  fill_mode_e     mode_i,
  input  logic           valid_i,
  output logic           wr_fire_o,
  output logic [PW-1:0]  wr_set_o,
  output logic           page_done_o,
  output logic           buf_done_o,
  output logic [PGW-1:0] page_idx_o,
  output logic           full_o
);

  logic           en_q;
  logic           full_q;
  logic [PW-1:0]  ptr_q;
  logic [PGW-1:0] page_q;
  logic           arm;
  logic           last_set;

  assign arm       = cap_en_i & ~en_q;
  assign wr_set_o  = arm ? '0 : ptr_q;
  assign wr_fire_o = valid_i & cap_en_i & ~src_sel_i & (~full_q | arm);
  assign last_set  = (wr_set_o == PW'(SETS - 1));

  assign page_done_o = wr_fire_o && (mode_i == MODE_1024)
                       && set_closes_page(32'(wr_set_o), SETS_PER_PAGE);
  assign buf_done_o  = wr_fire_o && (mode_i == MODE_128) && last_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      full_q <= 1'b0;
      ptr_q  <= '0;
      page_q <= '0;
    end else begin
      en_q <= cap_en_i;
      if (wr_fire_o)      ptr_q <= wr_set_o + PW'(1);
      else if (arm)       ptr_q <= '0;
      if (buf_done_o)     full_q <= 1'b1;
      else if (arm)       full_q <= 1'b0;
      if (page_done_o)    page_q <= wr_set_o[PW-1 -: PGW];
    end
  end

  assign page_idx_o = page_q;
  assign full_o     = full_q;

endmodule

// File: rtl/wavecap_status.sv
`timescale 1ns/1ps
module wavecap_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic ready_o,
  output logic irq_o
);

  logic ready_q;

  // A set event outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ready_q <= 1'b0;
    else if (set_i)  ready_q <= 1'b1;
    else if (clr_i)  ready_q <= 1'b0;
  end

  assign ready_o = ready_q;
  assign irq_o   = ready_q & mask_i;

endmodule

// File: rtl/wavecap_ctrl.sv
`timescale 1ns/1ps
module wavecap_ctrl
  import wavecap_pkg::*;
#(
  parameter  int unsigned DATA_W     = 32,
  parameter  int unsigned CH_N       = 4,
  parameter  int unsigned SETS       = 512,
  parameter  int unsigned PAGE_WORDS = 128,
  parameter  int unsigned ADDR_W     = 12,
  parameter  int unsigned HOST_BASE  = 'h800,
  localparam int unsigned DEPTH      = SETS * CH_N,
  localparam int unsigned SPP        = PAGE_WORDS / CH_N,
  localparam int unsigned PGW        = $clog2(DEPTH / PAGE_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en_i,
  input  logic                   src_sel_i,
  input  logic                   mode_i,
  input  logic                   irq_mask_i,
  input  logic                   status_clr_i,
  input  logic                   smp_valid_i,
  input  logic [CH_N*DATA_W-1:0] smp_data_i,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rd_valid_o,
  output logic                   ready_o,
  output logic [PGW-1:0]         page_o,
  output logic                   irq_o
);

  localparam int unsigned RW  = $clog2(SETS);
  localparam int unsigned CHW = $clog2(CH_N);

  // Named internal events, observed by the bound checker.
  logic          wr_fire;
  logic [RW-1:0] wr_set;
  logic          page_done;
  logic          buf_done;
  logic          cap_full;

  wavecap_fill #(
    .SETS          (SETS),
    .SETS_PER_PAGE (SPP)
  ) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en_i    (cap_en_i),
    .src_sel_i   (src_sel_i),
    .mode_i      (fill_mode_e'(mode_i)),
    .valid_i     (smp_valid_i),
    .wr_fire_o   (wr_fire),
    .wr_set_o    (wr_set),
    .page_done_o (page_done),
    .buf_done_o  (buf_done),
    .page_idx_o  (page_o),
    .full_o      (cap_full)
  );

  wavecap_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (page_done | buf_done),
    .clr_i   (status_clr_i),
    .mask_i  (irq_mask_i),
    .ready_o (ready_o),
    .irq_o   (irq_o)
  );

  // Host read decode: offset from the window base, split into row and lane.
  logic [ADDR_W-1:0] rd_off;
  logic              rd_hit;
  logic [RW-1:0]     rd_row;
  logic [CHW-1:0]    rd_lane;

  assign rd_off  = rd_addr_i - ADDR_W'(HOST_BASE);
  assign rd_hit  = addr_in_window(32'(rd_addr_i), HOST_BASE, DEPTH);
  assign rd_row  = rd_off[CHW +: RW];
  assign rd_lane = rd_off[CHW-1:0];

  logic [DATA_W-1:0] lane_rdata [CH_N];

  for (genvar c = 0; c < CH_N; c++) begin : g_lane
    wavecap_bank #(
      .DEPTH (SETS),
      .W     (DATA_W)
    ) u_bank (
      .clk     (clk),
      .we_i    (wr_fire),
      .waddr_i (wr_set),
      .wdata_i (smp_data_i[c*DATA_W +: DATA_W]),
      .re_i    (rd_en_i & rd_hit),
      .raddr_i (rd_row),
      .rdata_o (lane_rdata[c])
    );
  end

  logic           rd_valid_q;
  logic           rd_hit_q;
  logic [CHW-1:0] lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_hit_q   <= 1'b0;
      lane_q     <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      rd_hit_q   <= rd_en_i & rd_hit;
      lane_q     <= rd_lane;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_hit_q ? lane_rdata[lane_q] : '0;

endmodule

// File: rtl/wavecap_ctrl_chk.sv
`timescale 1ns/1ps
module wavecap_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cap_en_i,
  input logic src_sel_i,
  input logic irq_mask_i,
  input logic status_clr_i,
  input logic rd_en_i,
  input logic rd_valid_o,
  input logic ready_o,
  input logic irq_o,
  input logic wr_fire,
  input logic page_done,
  input logic buf_done
);

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && !status_clr_i |=> ready_o);

  assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr_i && !page_done && !buf_done |=> !ready_o);

  assert_event_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    page_done || buf_done |=> ready_o);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask_i |-> !irq_o);

  assert_irq_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && irq_mask_i |-> irq_o);

  assert_write_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> cap_en_i && !src_sel_i);

  assert_stop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> !wr_fire);

  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);

endmodule

bind wavecap_ctrl wavecap_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cap_en_i     (cap_en_i),
  .src_sel_i    (src_sel_i),
  .irq_mask_i   (irq_mask_i),
  .status_clr_i (status_clr_i),
  .rd_en_i      (rd_en_i),
  .rd_valid_o   (rd_valid_o),
  .ready_o      (ready_o),
  .irq_o        (irq_o),
  .wr_fire      (wr_fire),
  .page_done    (page_done),
  .buf_done     (buf_done)
);

// File: tb/wavecap_ctrl_tb.sv
`timescale 1ns/1ps
module wavecap_ctrl_tb;

  localparam int BASE = 'h800;
  localparam int SETS = 512;

  logic         clk;
  logic         rst_n;
  logic         cap_en_i, src_sel_i, mode_i, irq_mask_i, status_clr_i;
  logic         smp_valid_i;
  logic [127:0] smp_data_i;
  logic         rd_en_i;
  logic [11:0]  rd_addr_i;
  logic [31:0]  rd_data_o;
  logic         rd_valid_o, ready_o, irq_o;
  logic [3:0]   page_o;

  wavecap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cap_en_i(cap_en_i), .src_sel_i(src_sel_i),
    .mode_i(mode_i), .irq_mask_i(irq_mask_i), .status_clr_i(status_clr_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .ready_o(ready_o), .page_o(page_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int bptr   = 0;
  logic [31:0] model [2048];
  logic [31:0] exp_q [$];
  string       req_q [$];

  function automatic logic [31:0] pat(int tag, int set, int ch);
    return (32'(tag) << 24) | (32'(set) << 4) | 32'(ch);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic load_set(int tag);
    for (int c = 0; c < 4; c++) smp_data_i[c*32 +: 32] = pat(tag, bptr, c);
  endtask

  task automatic store_model(int tag);
    for (int c = 0; c < 4; c++) model[bptr*4 + c] = pat(tag, bptr, c);
    bptr = (bptr + 1) % SETS;
  endtask

  // Driver: offers one set; 'accept' is the bench's own expectation.
  task automatic send(int tag, bit accept);
    load_set(tag);
    smp_valid_i = 1'b1;
    tick();
    smp_valid_i = 1'b0;
    if (accept) store_model(tag);
  endtask

  function automatic logic [31:0] expect_rd(int addr);
    if (addr < BASE) return 32'h0;
    return model[addr - BASE];
  endfunction

  task automatic host_read(int addr, string req);
    exp_q.push_back(expect_rd(addr));
    req_q.push_back(req);
    rd_en_i   = 1'b1;
    rd_addr_i = 12'(addr);
    tick();
    rd_en_i = 1'b0;
  endtask

  // Write and read the same address in one cycle: old data expected.
  task automatic send_and_read(int tag, int addr);
    exp_q.push_back(expect_rd(addr));
    req_q.push_back("R9 same-cycle read");
    load_set(tag);
    smp_valid_i = 1'b1;
    rd_en_i     = 1'b1;
    rd_addr_i   = 12'(addr);
    tick();
    smp_valid_i = 1'b0;
    rd_en_i     = 1'b0;
    store_model(tag);
  endtask

  task automatic clear_flag;
    status_clr_i = 1'b1;
    tick();
    status_clr_i = 1'b0;
  endtask

  // Monitor: pops the scoreboard whenever read data is presented.
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected rd_valid", {31'd0, rd_valid_o}, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       r = req_q.pop_front();
        check(rd_data_o === e, r, rd_data_o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_en_i = 1'b0; src_sel_i = 1'b0; mode_i = 1'b0;
    irq_mask_i = 1'b0; status_clr_i = 1'b0; smp_valid_i = 1'b0;
    smp_data_i = '0; rd_en_i = 1'b0; rd_addr_i = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(ready_o == 1'b0, "R1 ready", {31'd0, ready_o}, 32'd0);
    check(irq_o == 1'b0, "R1 irq", {31'd0, irq_o}, 32'd0);
    check(rd_valid_o == 1'b0, "R1 rd_valid", {31'd0, rd_valid_o}, 32'd0);
    check(page_o == 4'd0, "R1 page", {28'd0, page_o}, 32'd0);

    // R4: 128-point one-shot fill; the set in the enable-rise cycle lands at 0x800
    cap_en_i = 1'b1;
    bptr = 0;
    for (int i = 0; i < 511; i++) send(1, 1'b1);
    check(ready_o == 1'b0, "R4 not ready before 512", {31'd0, ready_o}, 32'd0);
    send(1, 1'b1);
    check(ready_o == 1'b1, "R4 ready after 512", {31'd0, ready_o}, 32'd1);
    check(irq_o == 1'b0, "R7 masked irq", {31'd0, irq_o}, 32'd0);
    for (int i = 0; i < 3; i++) send(2, 1'b0);   // R4 dropped when full
    // R2 layout of every word
    for (int a = 0; a < 2048; a++) host_read(BASE + a, "R2 layout");

    // R7 mask
    irq_mask_i = 1'b1;
    tick();
    check(irq_o == 1'b1, "R7 irq with mask", {31'd0, irq_o}, 32'd1);
    // R6 clear
    clear_flag();
    check(ready_o == 1'b0, "R6 cleared", {31'd0, ready_o}, 32'd0);
    check(irq_o == 1'b0, "R7 irq after clear", {31'd0, irq_o}, 32'd0);

    // R8 re-arm: drop enable, raise it with a set in the same cycle
    cap_en_i = 1'b0;
    tick();
    cap_en_i = 1'b1;
    bptr = 0;
    for (int i = 0; i < 3; i++) send(4, 1'b1);
    for (int a = 0; a < 13; a++) host_read(BASE + a, "R8 restart at base");

    // R3 source select and disable drop sets, pointer held
    src_sel_i = 1'b1;
    for (int i = 0; i < 2; i++) send(5, 1'b0);
    src_sel_i = 1'b0;
    send(6, 1'b1);
    cap_en_i = 1'b0;
    for (int i = 0; i < 2; i++) send(7, 1'b0);
    for (int a = 12; a < 24; a++) host_read(BASE + a, "R3 dropped sets");
    check(ready_o == 1'b0, "R3 no flag", {31'd0, ready_o}, 32'd0);

    // R5 1024-point paged ring fill
    mode_i = 1'b1;
    tick();
    cap_en_i = 1'b1;
    bptr = 0;
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 31; i++) send(8, 1'b1);
      check(ready_o == 1'b0, "R5 no flag mid page", {31'd0, ready_o}, 32'd0);
      if (p == 1) status_clr_i = 1'b1;   // R6 event beats clear
      send(8, 1'b1);
      status_clr_i = 1'b0;
      check(ready_o == 1'b1, "R5 page flag", {31'd0, ready_o}, 32'd1);
      check(page_o == 4'(p), "R5 page index", {28'd0, page_o}, 32'(p));
      clear_flag();
    end
    for (int i = 0; i < 32; i++) send(9, 1'b1);
    check(ready_o == 1'b1, "R5 wrap flag", {31'd0, ready_o}, 32'd1);
    check(page_o == 4'd0, "R5 wrap page", {28'd0, page_o}, 32'd0);
    clear_flag();
    host_read(BASE, "R5 wrap overwrite");
    host_read(BASE + 128, "R5 page 1 kept");

    // R9 same-cycle read of the word being written
    send_and_read(10, BASE + bptr*4 + 2);
    host_read(BASE + (bptr - 1)*4 + 2, "R9 new data");

    // R10 outside the window
    host_read('h7FC, "R10 below base");
    host_read('h000, "R10 zero address");

    repeat (3) tick();
    check(rd_valid_o == 1'b0, "R9 idle", {31'd0, rd_valid_o}, 32'd0);
    check(exp_q.size() == 0, "R9 all reads returned", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule